// File: doc/BRIEF.md
# Unaligned Burst Strobe Generator

This block turns a write request stated in software terms into the beats of an incrementing burst and gives each beat its byte-lane write strobes. A request carries a start byte address, a byte count and a transfer size code. The block works out how many beats the burst needs. It then presents the beats one at a time on a valid/ready handshake. Each beat carries its address, an enable per byte lane of the data bus, and a flag on the final beat. The write data itself is not handled here. A data path uses the strobes to steer and mask its bytes.

Only the first beat may start at an address that is not a multiple of the size. Every beat stays inside its own size-aligned group of byte lanes. Lanes below the start address are disabled on the first beat. Lanes past the last requested byte are disabled on the final beat. This keeps neighbouring memory intact. A new request is taken only while no burst is in progress. A request with a byte count of zero is dropped without producing any beat.

Top module: `burst_strobe_gen`

## Requirements
- R1: After reset, and whenever no burst is active, beat_valid and beat_last are low, beat_strb is all zero and req_ready is high.
- R2: req_ready is low while a burst is in progress. A request offered during a burst is not taken and does not change that burst's beats.
- R3: A request whose byte count is zero is ignored: no beat appears and req_ready stays high.
- R4: The burst has ((end >> size) - (start >> size)) + 1 beats, where end = start + count - 1 and the beat width is 2^size bytes (size code 0,1,2,3 = 1,2,4,8 bytes). burst_len shows that number minus one and holds it for the whole burst.
- R5: The first beat's address is the start address exactly. Each later beat's address is the previous beat's size-aligned address plus 2^size.
- R6: On the first beat, a strobe bit is set only for lanes from the start address up to the end of its size-aligned group, and not past the last requested byte. Lane index is the byte address modulo the bus width in bytes.
- R7: On the final beat, lanes past the last requested byte are cleared.
- R8: A beat that is neither first nor last enables all 2^size lanes of the group picked by its address bits above the size.
- R9: beat_last is high on exactly the final beat. The handshake of that beat ends the burst.
- R10: While beat_valid is high and beat_ready is low, beat_addr, beat_strb and beat_last hold their values.
- R11: A single-beat request that is unaligned at both ends gets a strobe trimmed at both its start and its end address.
- R12: 16 bytes at 0x7 with 4-byte beats give 5 beats at addresses 0x7, 0x8, 0xC, 0x10 and 0x14. Their strobes are 0x80, 0x0F, 0xF0, 0x0F and 0x70, so byte 0x17 is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | CNT_W | Number of bytes to write |
| req_size | input | 2 | Beat size code, bytes = 2^code |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Beat accepted by the consumer |
| beat_addr | output | ADDR_W | Beat address (first beat unaligned) |
| beat_strb | output | DATA_BYTES | Byte-lane write enables |
| beat_last | output | 1 | Final beat of the burst |
| burst_len | output | CNT_W | Beat count minus one |

## Verification
A wrong remaining-beat count shows at the ports at the end of the burst. The burst gives one beat too many or too few, and beat_last lands on the wrong beat. A bad captured end address shows as wrong final-beat strobes. A bad size-aligned step shows from the second beat on, as a wrong address and a shifted lane group. Each of these faults appears within the burst where it arises, so the sweep sets every start offset within a few bus words against every byte count and size. It also stalls the consumer at irregular points, so that a state which moves under a stall is seen on the next beat.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
   typedef logic [1:0] bsg_size_t;

   function automatic int unsigned bsg_width(input bsg_size_t code);
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/bsg_plan.sv
module bsg_plan #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic [ADDR_W-1:0]      start_addr,
   input  logic [CNT_W-1:0]       byte_cnt,
   input  bsg_pkg::bsg_size_t     size,
   output logic [ADDR_W-1:0]      stop_addr,
   output logic [CNT_W-1:0]       beats_m1
);
   localparam int PAD_W = ADDR_W - CNT_W;

   logic [ADDR_W-1:0] cnt_ext;
   logic [ADDR_W-1:0] diff;

   always_comb begin
      cnt_ext   = {{PAD_W{1'b0}}, byte_cnt};
      stop_addr = start_addr + cnt_ext - ADDR_W'(1);
      diff      = (stop_addr >> size) - (start_addr >> size);
      beats_m1  = diff[CNT_W-1:0];
   end
endmodule

// File: rtl/bsg_lanes.sv
module bsg_lanes #(
   parameter int ADDR_W     = 32,
   parameter int DATA_BYTES = 8
) (
   input  logic [ADDR_W-1:0]      cur_addr,
   input  logic [ADDR_W-1:0]      stop_addr,
   input  bsg_pkg::bsg_size_t     size,
   output logic [DATA_BYTES-1:0]  lanes,
   output logic [ADDR_W-1:0]      step_addr
);
   localparam int LANE_LSB = $clog2(DATA_BYTES);

   logic [ADDR_W-1:0] sz_mask;
   logic [ADDR_W-1:0] grp_base;
   logic [ADDR_W-1:0] grp_top;
   logic [ADDR_W-1:0] hi_addr;
   logic [ADDR_W-1:0] word_base;

   always_comb begin
      sz_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
      grp_base  = cur_addr & ~sz_mask;
      grp_top   = grp_base + sz_mask;
      hi_addr   = (grp_top < stop_addr) ? grp_top : stop_addr;
      step_addr = grp_top + ADDR_W'(1);
   end

   generate
      if (LANE_LSB == 0) begin : g_narrow
         assign word_base = cur_addr;
      end else begin : g_wide
         assign word_base = {cur_addr[ADDR_W-1:LANE_LSB], {LANE_LSB{1'b0}}};
      end
   endgenerate

   generate
      for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
         logic [ADDR_W-1:0] byte_a;
         assign byte_a   = word_base + ADDR_W'(i);
         assign lanes[i] = (byte_a >= cur_addr) && (byte_a <= hi_addr);
      end
   endgenerate
endmodule

// File: rtl/burst_strobe_gen.sv
module burst_strobe_gen #(
   parameter int ADDR_W     = 32,
   parameter int DATA_BYTES = 8,
   parameter int CNT_W      = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [CNT_W-1:0]       req_bytes,
   input  logic [1:0]             req_size,
   output logic                   beat_valid,
   input  logic                   beat_ready,
   output logic [ADDR_W-1:0]      beat_addr,
   output logic [DATA_BYTES-1:0]  beat_strb,
   output logic                   beat_last,
   output logic [CNT_W-1:0]       burst_len
);
   localparam int LANE_LSB = $clog2(DATA_BYTES);

   generate
      if ((1 << LANE_LSB) != DATA_BYTES) begin : g_bad_bus
         $error("DATA_BYTES must be a power of two");
      end
      if (DATA_BYTES > 128) begin : g_big_bus
         $error("DATA_BYTES too large");
      end
      if (ADDR_W <= CNT_W || ADDR_W <= LANE_LSB) begin : g_bad_addr
         $error("ADDR_W must exceed CNT_W and the lane index width");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic                  busy_q;
   logic [ADDR_W-1:0]     cur_q;
   logic [ADDR_W-1:0]     stop_q;
   bsg_pkg::bsg_size_t    size_q;
   logic [CNT_W-1:0]      left_q;
   logic [CNT_W-1:0]      len_q;

   logic [ADDR_W-1:0]     plan_stop;
   logic [CNT_W-1:0]      plan_m1;
   logic [DATA_BYTES-1:0] lane_en;
   logic [ADDR_W-1:0]     step_addr;
   logic                  take;
   logic                  fire;

   bsg_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
      .start_addr (req_addr),
      .byte_cnt   (req_bytes),
      .size       (req_size),
      .stop_addr  (plan_stop),
      .beats_m1   (plan_m1)
   );

   bsg_lanes #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_lanes (
      .cur_addr   (cur_q),
      .stop_addr  (stop_q),
      .size       (size_q),
      .lanes      (lane_en),
      .step_addr  (step_addr)
   );

   assign take = req_valid && !busy_q && (req_bytes != '0);
   assign fire = busy_q && beat_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cur_q  <= '0;
         stop_q <= '0;
         size_q <= '0;
         left_q <= '0;
         len_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         cur_q  <= req_addr;
         stop_q <= plan_stop;
         size_q <= req_size;
         left_q <= plan_m1;
         len_q  <= plan_m1;
      end else if (fire) begin
         if (left_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cur_q  <= step_addr;
            left_q <= left_q - CNT_W'(1);
         end
      end
   end

   assign req_ready  = !busy_q;
   assign beat_valid = busy_q;
   assign beat_addr  = cur_q;
   assign beat_strb  = busy_q ? lane_en : '0;
   assign beat_last  = busy_q && (left_q == '0);
   assign burst_len  = len_q;
endmodule

// File: rtl/bsg_chk.sv
module bsg_chk #(
   parameter int ADDR_W     = 32,
   parameter int DATA_BYTES = 8,
   parameter int CNT_W      = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [CNT_W-1:0]      req_bytes,
   input logic                  beat_valid,
   input logic                  beat_ready,
   input logic [ADDR_W-1:0]     beat_addr,
   input logic [DATA_BYTES-1:0] beat_strb,
   input logic                  beat_last,
   input logic [CNT_W-1:0]      burst_len,
   input logic [1:0]            size_cur
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid |-> (beat_strb == '0) && !beat_last);

   // R2
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> !req_ready);

   // R3
   zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_bytes == '0)) |=> !beat_valid);

   // R4
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !(beat_ready && beat_last)) |=> $stable(burst_len));

   // R6
   strb_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (beat_strb != '0) && ($countones(beat_strb) <= (1 << size_cur)));

   // R9
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ready && beat_last) |=> !beat_valid);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_addr)
                                      && $stable(beat_strb) && $stable(beat_last));
endmodule

bind burst_strobe_gen bsg_chk #(
   .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)
) u_bsg_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_bytes  (req_bytes),
   .beat_valid (beat_valid),
   .beat_ready (beat_ready),
   .beat_addr  (beat_addr),
   .beat_strb  (beat_strb),
   .beat_last  (beat_last),
   .burst_len  (burst_len),
   .size_cur   (size_q)
);

// File: tb/test_burst_strobe_gen.sv
`timescale 1ns/1ps
module test_burst_strobe_gen;
   localparam int ADDR_W = 32;
   localparam int DB     = 8;
   localparam int CNT_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic [CNT_W-1:0]  req_bytes;
   logic [1:0]        req_size;
   logic              beat_valid;
   logic              beat_ready;
   logic [ADDR_W-1:0] beat_addr;
   logic [DB-1:0]     beat_strb;
   logic              beat_last;
   logic [CNT_W-1:0]  burst_len;

   int checks = 0;
   int errors = 0;
   int stall_seed = 0;
   bit done = 0;

   always #2 clk = ~clk;

   burst_strobe_gen #(.ADDR_W(ADDR_W), .DATA_BYTES(DB), .CNT_W(CNT_W)) i_burst_strobe_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_bytes(req_bytes), .req_size(req_size),
      .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
      .beat_strb(beat_strb), .beat_last(beat_last), .burst_len(burst_len)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DB-1:0] exp_strb(input longint cur, input longint stop, input int sz);
      logic [DB-1:0] s = '0;
      longint al = cur - (cur % sz);
      longint hi = (al + sz - 1 < stop) ? al + sz - 1 : stop;
      for (longint b = cur; b <= hi; b++) s[b % DB] = 1'b1;
      return s;
   endfunction

   task automatic run_req(input int start, input int nbytes, input int code, input bit stall);
      int sz = 1 << code;
      longint stop = start + nbytes - 1;
      longint cur;
      int n = 0;
      int k = 0;
      bit prev_stall = 0;
      logic [ADDR_W-1:0] p_addr;
      logic [DB-1:0] p_strb;
      logic p_last;
      string stag;
      @(negedge clk);
      req_valid = 1'b1; req_addr = start; req_bytes = nbytes; req_size = code;
      beat_ready = 1'b0;
      @(negedge clk);
      if (nbytes == 0) begin
         chk(beat_valid == 1'b0, "R3", "zero count beat_valid", beat_valid, 0);
         chk(req_ready == 1'b1, "R3", "zero count req_ready", req_ready, 1);
         req_valid = 1'b0;
         return;
      end
      cur = start;
      while (cur <= stop) begin
         cur = cur - (cur % sz) + sz;
         n++;
      end
      chk(n == ((stop / sz) - (start / sz) + 1), "R4", "beat count formula", n,
          (stop / sz) - (start / sz) + 1);
      req_addr = start + 5; req_bytes = 3; req_size = 2'd0;
      cur = start;
      while (k < n) begin
         chk(beat_valid == 1'b1, "R2", "beat_valid during burst", beat_valid, 1);
         chk(req_ready == 1'b0, "R2", "req_ready during burst", req_ready, 0);
         chk(burst_len == CNT_W'(n - 1), "R4", "burst_len", burst_len, n - 1);
         chk(beat_addr == ADDR_W'(k == 0 ? cur : cur - (cur % sz)), "R5", "beat_addr",
             beat_addr, k == 0 ? cur : cur - (cur % sz));
         stag = (n == 1) ? "R11" : (k == 0) ? "R6" : (k == n - 1) ? "R7" : "R8";
         chk(beat_strb == exp_strb(cur, stop, sz), stag, "beat_strb", beat_strb,
             exp_strb(cur, stop, sz));
         chk(beat_last == (k == n - 1), "R9", "beat_last", beat_last, k == n - 1);
         if (prev_stall)
            chk(beat_addr == p_addr && beat_strb == p_strb && beat_last == p_last,
                "R10", "held under stall", beat_addr, p_addr);
         stall_seed++;
         beat_ready = !(stall && ((stall_seed * 7 + 3) % 5 == 0));
         prev_stall = !beat_ready;
         p_addr = beat_addr; p_strb = beat_strb; p_last = beat_last;
         if (beat_ready) begin
            k++;
            cur = cur - (cur % sz) + sz;
            if (k == n) req_valid = 1'b0;
         end
         @(negedge clk);
      end
      beat_ready = 1'b0;
      chk(beat_valid == 1'b0, "R9", "burst ended", beat_valid, 0);
      chk(req_ready == 1'b1, "R1", "idle req_ready", req_ready, 1);
      chk(beat_strb == '0, "R1", "idle strobe", beat_strb, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog expired act=0 exp=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] ex_addr [5];
      logic [DB-1:0]     ex_strb [5];
      ex_addr = '{32'h7, 32'h8, 32'hC, 32'h10, 32'h14};
      ex_strb = '{8'h80, 8'h0F, 8'hF0, 8'h0F, 8'h70};
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_bytes = '0; req_size = '0;
      beat_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(beat_valid == 1'b0, "R1", "reset beat_valid", beat_valid, 0);
      chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
      chk(beat_strb == '0 && beat_last == 1'b0, "R1", "reset strobe", beat_strb, 0);
      rst_n = 1'b1;

      // R12 directed example
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h7; req_bytes = 12'd16; req_size = 2'd2;
      @(negedge clk);
      req_valid = 1'b0; beat_ready = 1'b1;
      for (int i = 0; i < 5; i++) begin
         chk(beat_valid && beat_addr == ex_addr[i], "R12", "example addr", beat_addr, ex_addr[i]);
         chk(beat_strb == ex_strb[i], "R12", "example strb", beat_strb, ex_strb[i]);
         chk(beat_last == (i == 4), "R12", "example last", beat_last, i == 4);
         @(negedge clk);
      end
      chk(beat_valid == 1'b0, "R12", "example ends", beat_valid, 0);
      beat_ready = 1'b0;

      // R11 directed: one beat trimmed at both ends
      run_req(9, 2, 3, 1'b0);

      for (int code = 0; code < 4; code++)
         for (int st = 0; st < 24; st++)
            for (int nb = 0; nb < 19; nb++)
               run_req(st, nb, code, 1'b1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule